// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two entries of a page table that lives in ordinary memory. The address is cut into three fields: bits 31:22 pick an entry in the top-level directory, bits 21:12 pick an entry in the second-level table, and bits 11:0 are the byte offset inside a 4 kB page. The directory's location is given by a root frame number input. Each table entry is 32 bits wide and holds a frame number in bits 31:12 and a present flag in bit 0. Bits 11:1 are attribute bits that the walker does not interpret.

A client offers a request when the walker shows it is ready. The walker then issues at most two dependent reads on a memory port that allows one outstanding request at a time. The memory may answer each read after any number of cycles. The walk ends with a one-cycle result. The result is either the physical address, or a page fault flag together with the virtual address that caused it. A missing entry at either level ends the walk early.

Top module: `pt_walker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `tr_ready` is 1, and both `mem_req` and `res_valid` are 0.
- R2: A request is taken only on a clock edge where `tr_valid` and `tr_ready` are both 1. `tr_ready` stays 0 from that edge until the result has been delivered. Requests offered while it is 0 are dropped and start no walk.
- R3: The first read goes to address root*4096 + vaddr[31:22]*4. Here root is the value of `root_frame` when the request was taken; later changes to `root_frame` do not affect a walk already in progress.
- R4: When the directory entry has bit 0 set, the second read goes to address entry[31:12]*4096 + vaddr[21:12]*4.
- R5: When both entries have bit 0 set, the result has `res_fault`=0 and `res_paddr` = {table entry[31:12], vaddr[11:0]}. Entry bits 11:1 have no effect on the address.
- R6: When the directory entry has bit 0 clear, the walk ends with `res_fault`=1 and `res_paddr`=0, and no second read is made.
- R7: When the second-level entry has bit 0 clear, the walk ends with `res_fault`=1 and `res_paddr`=0.
- R8: `mem_req` stays 1 with `mem_addr` unchanged until a cycle with `mem_rvalid`=1. The read completes in that cycle, whatever the latency.
- R9: `res_valid` is a one-cycle pulse one cycle after the final read completes. `res_vaddr` then carries the translated or faulting virtual address. `tr_ready` returns to 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tr_valid | input | 1 | Translation request offered |
| tr_vaddr | input | 32 | Virtual address to translate |
| tr_ready | output | 1 | Walker idle, request can be taken |
| root_frame | input | 20 | Frame number of the top-level directory |
| mem_req | output | 1 | Read request to memory, held until answered |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rvalid | input | 1 | Read data valid, completes the pending read |
| mem_rdata | input | 32 | Entry returned by memory |
| res_valid | output | 1 | Result pulse |
| res_fault | output | 1 | Result is a page fault |
| res_paddr | output | 32 | Physical address, zero on fault |
| res_vaddr | output | 32 | Virtual address of the finished walk |

## Verification
The bench probes the extreme fields, including all-ones directory and table indices and all-ones offsets. A wrong shift or a swapped field there would send the read to the wrong entry or corrupt the offset. It plants entries with attribute bits set and present bits clear at each level. A design that tested the wrong bit, or read a second entry after a directory miss, would produce the wrong fault or an extra read. It also changes `root_frame` in the middle of a walk and offers requests while the walker is busy. A design that sampled the root late, or took a second request, would read the wrong directory or start a phantom walk. Read latencies from zero to several cycles catch an address that moves before the answer arrives.

// File: rtl/pt_walker_pkg.sv
// Shared types of the page table walker.
// Assumes: nothing beyond the standard language.
package pt_walker_pkg;

    // Walk phases: idle, reading directory entry, reading table entry, reporting.
    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_DIR  = 2'd1,
        WS_TBL  = 2'd2,
        WS_DONE = 2'd3
    } walk_state_e;

    // Number of table levels walked.
    localparam int unsigned NUM_LEVELS = 2;

endpackage

// File: rtl/pt_vaddr_split.sv
// Splits a virtual address into directory index, table index and page offset.
// Assumes: VA_W == DIR_W + TBL_W + OFF_W, directory index in the top bits.
module pt_vaddr_split #(
    parameter int unsigned VA_W  = 32,
    parameter int unsigned DIR_W = 10,
    parameter int unsigned TBL_W = 10,
    parameter int unsigned OFF_W = 12
) (
    input  logic [VA_W-1:0]  vaddr,
    output logic [DIR_W-1:0] dir_idx,
    output logic [TBL_W-1:0] tbl_idx,
    output logic [OFF_W-1:0] offset
);
    localparam int unsigned TBL_LO = OFF_W;
    localparam int unsigned DIR_LO = OFF_W + TBL_W;

    // Field extraction.
    always_comb begin
        dir_idx = vaddr[DIR_LO +: DIR_W];
        tbl_idx = vaddr[TBL_LO +: TBL_W];
        offset  = vaddr[OFF_W-1:0];
    end
endmodule

// File: rtl/pt_entry_addr.sv
// Forms the byte address of a table entry from the table's frame and an index.
// Assumes: FRAME_W + OFF_W == PA_W, entries of 2**ENT_LOG2 bytes.
module pt_entry_addr #(
    parameter int unsigned PA_W     = 32,
    parameter int unsigned FRAME_W  = 20,
    parameter int unsigned OFF_W    = 12,
    parameter int unsigned IDX_W    = 10,
    parameter int unsigned ENT_LOG2 = 2
) (
    input  logic [FRAME_W-1:0] frame,
    input  logic [IDX_W-1:0]   idx,
    output logic [PA_W-1:0]    addr
);
    logic [PA_W-1:0] base;
    logic [PA_W-1:0] disp;

    // Frame base plus scaled index.
    always_comb begin
        base = {frame, {OFF_W{1'b0}}};
        disp = PA_W'(idx) << ENT_LOG2;
        addr = base + disp;
    end
endmodule

// File: rtl/pt_entry_decode.sv
// Decodes a table entry into its present flag and frame number.
// Assumes: frame in the top FRAME_W bits, present flag at bit PRES_BIT;
// remaining attribute bits are not interpreted.
module pt_entry_decode #(
    parameter int unsigned ENT_W    = 32,
    parameter int unsigned FRAME_W  = 20,
    parameter int unsigned PRES_BIT = 0
) (
    input  logic [ENT_W-1:0]   entry,
    output logic               present,
    output logic [FRAME_W-1:0] frame
);
    logic unused_attr;

    // Field extraction; attribute bits are folded into an unused sink.
    always_comb begin
        present     = entry[PRES_BIT];
        frame       = entry[ENT_W-1 -: FRAME_W];
        unused_attr = ^entry;
    end
endmodule

// File: rtl/pt_walk_ctrl.sv
// Sequencer of the two-level walk: takes a request, issues the directory read,
// then the table read, and reports a physical address or a fault.
// Assumes: one outstanding memory read, which completes in the cycle mem_rvalid is 1.
module pt_walk_ctrl
    import pt_walker_pkg::*;
#(
    parameter int unsigned VA_W    = 32,
    parameter int unsigned PA_W    = 32,
    parameter int unsigned FRAME_W = 20,
    parameter int unsigned OFF_W   = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tr_valid,
    input  logic [VA_W-1:0]    tr_vaddr,
    output logic               tr_ready,
    input  logic [FRAME_W-1:0] root_frame,
    input  logic [OFF_W-1:0]   off_q,
    input  logic [PA_W-1:0]    dir_addr,
    input  logic [PA_W-1:0]    tbl_addr,
    input  logic               ent_present,
    input  logic [FRAME_W-1:0] ent_frame,
    input  logic               mem_rvalid,
    output logic               mem_req,
    output logic [PA_W-1:0]    mem_addr,
    output logic [VA_W-1:0]    vaddr_q,
    output logic [FRAME_W-1:0] root_q,
    output logic [FRAME_W-1:0] tframe_q,
    output logic               res_valid,
    output logic               res_fault,
    output logic [PA_W-1:0]    res_paddr
);
    walk_state_e     state;
    logic            fault_q;
    logic [PA_W-1:0] paddr_q;

    // Walk state and captured operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= WS_IDLE;
            vaddr_q  <= '0;
            root_q   <= '0;
            tframe_q <= '0;
            fault_q  <= 1'b0;
            paddr_q  <= '0;
        end else begin
            case (state)
                WS_IDLE: begin
                    if (tr_valid) begin
                        vaddr_q <= tr_vaddr;
                        root_q  <= root_frame;
                        state   <= WS_DIR;
                    end
                end
                WS_DIR: begin
                    if (mem_rvalid) begin
                        if (ent_present) begin
                            tframe_q <= ent_frame;
                            state    <= WS_TBL;
                        end else begin
                            fault_q <= 1'b1;
                            paddr_q <= '0;
                            state   <= WS_DONE;
                        end
                    end
                end
                WS_TBL: begin
                    if (mem_rvalid) begin
                        fault_q <= !ent_present;
                        paddr_q <= ent_present ? {ent_frame, off_q} : '0;
                        state   <= WS_DONE;
                    end
                end
                default: state <= WS_IDLE;
            endcase
        end
    end

    // Handshake, memory request and result outputs.
    always_comb begin
        tr_ready  = (state == WS_IDLE);
        mem_req   = (state == WS_DIR) || (state == WS_TBL);
        mem_addr  = (state == WS_DIR) ? dir_addr :
                    (state == WS_TBL) ? tbl_addr : '0;
        res_valid = (state == WS_DONE);
        res_fault = fault_q;
        res_paddr = paddr_q;
    end
endmodule

// File: rtl/pt_walker.sv
// Two-level page table walker top: splits the held virtual address, forms the
// entry address of each level, decodes returned entries and runs the sequencer.
// Assumes: 4-byte entries, frame in bits 31:12, present flag in bit 0.
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int unsigned VA_W     = 32,
    parameter int unsigned PA_W     = 32,
    parameter int unsigned DIR_W    = 10,
    parameter int unsigned TBL_W    = 10,
    parameter int unsigned OFF_W    = 12,
    parameter int unsigned ENT_LOG2 = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tr_valid,
    input  logic [VA_W-1:0]       tr_vaddr,
    output logic                  tr_ready,
    input  logic [PA_W-OFF_W-1:0] root_frame,
    output logic                  mem_req,
    output logic [PA_W-1:0]       mem_addr,
    input  logic                  mem_rvalid,
    input  logic [(8<<ENT_LOG2)-1:0] mem_rdata,
    output logic                  res_valid,
    output logic                  res_fault,
    output logic [PA_W-1:0]       res_paddr,
    output logic [VA_W-1:0]       res_vaddr
);
    localparam int unsigned FRAME_W = PA_W - OFF_W;
    localparam int unsigned ENT_W   = 8 << ENT_LOG2;
    localparam int unsigned IDX_MAX = (DIR_W > TBL_W) ? DIR_W : TBL_W;

    logic [VA_W-1:0]    vaddr_q;
    logic [FRAME_W-1:0] root_q;
    logic [FRAME_W-1:0] tframe_q;
    logic [DIR_W-1:0]   dir_idx;
    logic [TBL_W-1:0]   tbl_idx;
    logic [OFF_W-1:0]   off_q;
    logic               ent_present;
    logic [FRAME_W-1:0] ent_frame;

    logic [FRAME_W-1:0] lvl_frame [NUM_LEVELS];
    logic [IDX_MAX-1:0] lvl_idx   [NUM_LEVELS];
    logic [PA_W-1:0]    lvl_addr  [NUM_LEVELS];

    pt_vaddr_split #(
        .VA_W (VA_W), .DIR_W(DIR_W), .TBL_W(TBL_W), .OFF_W(OFF_W)
    ) i_split (
        .vaddr  (vaddr_q),
        .dir_idx(dir_idx),
        .tbl_idx(tbl_idx),
        .offset (off_q)
    );

    // Per-level table frame and index selection.
    always_comb begin
        lvl_frame[0] = root_q;
        lvl_idx[0]   = IDX_MAX'(dir_idx);
        lvl_frame[1] = tframe_q;
        lvl_idx[1]   = IDX_MAX'(tbl_idx);
    end

    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
        pt_entry_addr #(
            .PA_W(PA_W), .FRAME_W(FRAME_W), .OFF_W(OFF_W),
            .IDX_W(IDX_MAX), .ENT_LOG2(ENT_LOG2)
        ) i_eaddr (
            .frame(lvl_frame[g]),
            .idx  (lvl_idx[g]),
            .addr (lvl_addr[g])
        );
    end

    pt_entry_decode #(
        .ENT_W(ENT_W), .FRAME_W(FRAME_W), .PRES_BIT(0)
    ) i_dec (
        .entry  (mem_rdata),
        .present(ent_present),
        .frame  (ent_frame)
    );

    pt_walk_ctrl #(
        .VA_W(VA_W), .PA_W(PA_W), .FRAME_W(FRAME_W), .OFF_W(OFF_W)
    ) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tr_valid   (tr_valid),
        .tr_vaddr   (tr_vaddr),
        .tr_ready   (tr_ready),
        .root_frame (root_frame),
        .off_q      (off_q),
        .dir_addr   (lvl_addr[0]),
        .tbl_addr   (lvl_addr[1]),
        .ent_present(ent_present),
        .ent_frame  (ent_frame),
        .mem_rvalid (mem_rvalid),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .vaddr_q    (vaddr_q),
        .root_q     (root_q),
        .tframe_q   (tframe_q),
        .res_valid  (res_valid),
        .res_fault  (res_fault),
        .res_paddr  (res_paddr)
    );

    // Result virtual address is the captured request address.
    always_comb res_vaddr = vaddr_q;
endmodule

// File: rtl/pt_walker_chk.sv
// Protocol checker for the page table walker, bound to the top module.
// Assumes: synchronous active-low reset.
module pt_walker_chk #(
    parameter int unsigned PA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tr_valid,
    input logic            tr_ready,
    input logic            mem_req,
    input logic [PA_W-1:0] mem_addr,
    input logic            mem_rvalid,
    input logic            res_valid,
    input logic            res_fault,
    input logic [PA_W-1:0] res_paddr
);
    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tr_valid && tr_ready |=> !tr_ready && mem_req);

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

    // R8
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_req) |-> $past(mem_rvalid));

    // R6
    fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_fault |-> res_paddr == '0);

    // R9
    result_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid && tr_ready);

    // R9
    no_req_during_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !mem_req && !tr_ready);
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W)) i_pt_walker_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tr_valid  (tr_valid),
    .tr_ready  (tr_ready),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_rvalid(mem_rvalid),
    .res_valid (res_valid),
    .res_fault (res_fault),
    .res_paddr (res_paddr)
);

// File: tb/test_pt_walker.sv
// Bench for the page table walker: vector table plus directed corner tests.
module test_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tr_valid = 1'b0;
    logic [31:0] tr_vaddr = '0;
    logic        tr_ready;
    logic [19:0] root_frame = 20'h00010;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        res_valid;
    logic        res_fault;
    logic [31:0] res_paddr;
    logic [31:0] res_vaddr;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pt_walker i_pt_walker (
        .clk(clk), .rst_n(rst_n), .tr_valid(tr_valid), .tr_vaddr(tr_vaddr),
        .tr_ready(tr_ready), .root_frame(root_frame), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .res_valid(res_valid), .res_fault(res_fault), .res_paddr(res_paddr),
        .res_vaddr(res_vaddr)
    );

    // Sparse model of physical memory, absent words read as zero.
    logic [31:0] pmem [int unsigned];

    function automatic logic [31:0] rd(input logic [31:0] a);
        return pmem.exists(a) ? pmem[a] : 32'h0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Memory responder: answers after lat_cfg cycles, logs addresses, checks stability.
    int          lat_cfg = 0;
    int          wait_cnt = 0;
    int          nreads = 0;
    int          stable_err = 0;
    logic [31:0] held_addr = '0;
    logic [31:0] rd_log [4];

    always @(negedge clk) begin
        if (!rst_n) begin
            mem_rvalid = 1'b0;
            wait_cnt   = 0;
        end else if (mem_rvalid) begin
            mem_rvalid = 1'b0;
        end else if (mem_req) begin
            if (wait_cnt == 0) held_addr = mem_addr;
            else if (mem_addr !== held_addr) stable_err++;
            if (wait_cnt >= lat_cfg) begin
                mem_rvalid = 1'b1;
                mem_rdata  = rd(mem_addr);
                rd_log[nreads % 4] = mem_addr;
                nreads++;
                wait_cnt = 0;
            end else begin
                wait_cnt++;
            end
        end
    end

    // Offer a request for one cycle; the walker is idle so it is taken.
    task automatic start_walk(input logic [31:0] va, input int lat);
        @(negedge clk);
        lat_cfg  = lat;
        nreads   = 0;
        tr_valid = 1'b1;
        tr_vaddr = va;
        @(negedge clk);
        tr_valid = 1'b0;
    endtask

    task automatic wait_result();
        int guard = 0;
        while (!res_valid && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    // Stimulus and expected results: vaddr, paddr, fault, reads, latency.
    typedef struct packed {
        logic [31:0] va;
        logic [31:0] pa;
        logic        flt;
        logic [1:0]  nrd;
        logic [3:0]  lat;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{32'h0040_0000, 32'h1234_5000, 1'b0, 2'd2, 4'd0},
        '{32'h007F_FFFF, 32'hABCD_EFFF, 1'b0, 2'd2, 4'd3},
        '{32'hFFFF_F123, 32'hFFFF_F123, 1'b0, 2'd2, 4'd1},
        '{32'h0080_0ABC, 32'h0000_0000, 1'b1, 2'd1, 4'd5},
        '{32'h0040_5777, 32'h0000_0000, 1'b1, 2'd2, 4'd2},
        '{32'h0000_0010, 32'h0000_0000, 1'b1, 2'd1, 4'd0}
    };

    // Watchdog: an expired run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] a1;
        logic [31:0] a2;
        // Page tables: directory at frame 0x10, second root at 0x50.
        pmem[32'h0001_0000 + 32'd1 * 4]     = 32'h0002_0001;
        pmem[32'h0001_0000 + 32'h3FF * 4]   = 32'h0003_0001;
        pmem[32'h0001_0000 + 32'd2 * 4]     = 32'h0004_0FFE;
        pmem[32'h0002_0000 + 32'd0 * 4]     = 32'h1234_5001;
        pmem[32'h0002_0000 + 32'h3FF * 4]   = 32'hABCD_EFFF;
        pmem[32'h0002_0000 + 32'd5 * 4]     = 32'h5555_5FFE;
        pmem[32'h0003_0000 + 32'h3FF * 4]   = 32'hFFFF_F001;
        pmem[32'h0005_0000 + 32'd1 * 4]     = 32'h0006_0001;
        pmem[32'h0006_0000 + 32'd0 * 4]     = 32'h7777_7001;

        // R1: reset state, during and right after reset.
        repeat (3) @(negedge clk);
        check("R1 ready in reset", {31'd0, tr_ready}, 32'd1);
        check("R1 no mem_req in reset", {31'd0, mem_req}, 32'd0);
        check("R1 no result in reset", {31'd0, res_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", {31'd0, tr_ready}, 32'd1);
        check("R1 idle mem after reset", {31'd0, mem_req}, 32'd0);

        // Vector table walk: R3 R4 R5 R6 R7 R8 R9.
        for (int i = 0; i < NV; i++) begin
            start_walk(VECS[i].va, int'(VECS[i].lat));
            check("R2 busy after accept", {31'd0, tr_ready}, 32'd0);
            wait_result();
            check("R9 result pulse", {31'd0, res_valid}, 32'd1);
            check(VECS[i].flt ? "R6/R7 fault flag" : "R5 no fault",
                  {31'd0, res_fault}, {31'd0, VECS[i].flt});
            check(VECS[i].flt ? "R6/R7 paddr zero" : "R5 paddr",
                  res_paddr, VECS[i].pa);
            check("R9 res_vaddr", res_vaddr, VECS[i].va);
            check(VECS[i].nrd == 2'd1 ? "R6 single read" : "R4 two reads",
                  nreads, {30'd0, VECS[i].nrd});
            a1 = 32'h0001_0000 + {20'd0, VECS[i].va[31:22], 2'b00};
            check("R3 directory address", rd_log[0], a1);
            if (VECS[i].nrd == 2'd2) begin
                a2 = {rd(a1)[31:12], 12'h000} + {20'd0, VECS[i].va[21:12], 2'b00};
                check("R4 table address", rd_log[1], a2);
            end
            @(negedge clk);
            check("R9 pulse ends", {31'd0, res_valid}, 32'd0);
            check("R9 ready again", {31'd0, tr_ready}, 32'd1);
        end

        // R3: root sampled at acceptance, changed mid-walk.
        root_frame = 20'h00050;
        start_walk(32'h0040_0000, 3);
        root_frame = 20'h00010;
        wait_result();
        check("R3 root sampled at accept addr", rd_log[0], 32'h0005_0004);
        check("R3 root sampled at accept paddr", res_paddr, 32'h7777_7000);
        @(negedge clk);

        // R2: requests offered while busy are ignored.
        start_walk(32'h0040_0123, 6);
        tr_valid = 1'b1;
        tr_vaddr = 32'hFFFF_F456;
        for (int k = 0; k < 3; k++) begin
            check("R2 not ready while busy", {31'd0, tr_ready}, 32'd0);
            @(negedge clk);
        end
        tr_valid = 1'b0;
        wait_result();
        check("R2 result is first request", res_vaddr, 32'h0040_0123);
        check("R2 first request paddr", res_paddr, 32'h1234_5123);
        repeat (4) @(negedge clk);
        check("R2 no phantom walk", {31'd0, mem_req}, 32'd0);
        check("R2 reads of single walk", nreads, 32'd2);

        // R8: address stable over every wait cycle.
        check("R8 address stable while pending", stable_err, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule